// File: doc/BRIEF.md
# Four-Plane Raster-Operation Rectangle Copier

This block walks a rectangle of bytes in four parallel bit planes and, for each byte, combines a source byte with the byte already at the destination. Each plane has its own logic function and its own inversion controls. The result is written back under a plane enable and under edge masks on the first and last byte of every line. The rectangle is described by a width (byte count minus one), a line count, source and destination byte addresses, and signed pitches that step from one line to the next. A direction flag walks each line from right to left and the lines from bottom to top, so that copies between overlapping areas can be done safely.

The caller presents a full parameter set and pulses `start` while the block is idle. The block then owns a single synchronous memory port that reaches all four planes at one shared address, with one cycle of read latency. For each byte it issues a source read, then a destination read, then a write. When the last byte has been written it pulses `done`. Source bytes are rotated right before the logic function is applied. The bits that the rotate pushes out enter the next byte of the same line.

Top module: `planar_blit`

## Requirements
- R1: Plane p takes its function from bit p of `op_hi` and bit p of `op_lo`. The code {op_hi,op_lo} = 00 writes the source, 01 writes source AND destination, 10 writes source OR destination, and 11 writes source XOR destination.
- R2: Bit p of `src_inv` inverts plane p's rotated source byte before the function is applied. Bit p of `dst_inv` does the same for plane p's destination byte. The bits of the destination that are kept unchanged under the edge masks keep their original, uninverted value.
- R3: `mem_we[p]` is asserted only when bit p of the captured `plane_en` is set. A plane whose bit is clear is never modified.
- R4: In the first byte of each line, only the bits set in `head_mask` take the new value. In the last byte, only the bits set in `tail_mask` do. In every other byte all eight bits do. A line one byte wide uses `head_mask & tail_mask`.
- R5: Each line holds `span + 1` bytes and the rectangle holds `lines` lines. Line k starts at the start address plus k times the sign-extended 9-bit pitch. Each address wraps modulo 2^18.
- R6: With `reverse` = 0, bytes within a line are taken at increasing addresses. With `reverse` = 1, they are taken at decreasing addresses, starting from the given addresses, and the caller supplies negative pitches.
- R7: Source bytes are rotated right by `rot` bits. The low `rot` bits of the previous source byte of the same line fill the vacated top bits. The first byte of each line receives zeros there.
- R8: Each byte uses three consecutive cycles in this order: a source read, a destination read, and a write to the destination address. `busy` stays high for 3N+1 cycles for N bytes. `done` is high for exactly the final one of those cycles.
- R9: After reset, `busy`, `done`, `mem_rd` and `mem_we` are all low.
- R10: `start` has no effect while `busy` is high. A start with `lines` = 0 gives one busy cycle with `done` and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| plane_en | input | 4 | Per-plane write enable |
| op_lo | input | 4 | Low bit of each plane's function code |
| op_hi | input | 4 | High bit of each plane's function code |
| src_inv | input | 4 | Per-plane source inversion |
| dst_inv | input | 4 | Per-plane destination inversion |
| head_mask | input | 8 | Bit mask for the first byte of each line |
| tail_mask | input | 8 | Bit mask for the last byte of each line |
| span | input | 16 | Bytes per line minus one |
| lines | input | 10 | Number of lines |
| src_base | input | 18 | Source byte address of the first byte |
| dst_base | input | 18 | Destination byte address of the first byte |
| src_step | input | 9 | Source line pitch, two's complement |
| dst_step | input | 9 | Destination line pitch, two's complement |
| rot | input | 3 | Right-rotate amount for source bytes |
| reverse | input | 1 | Walk right-to-left and bottom-to-top |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 18 | Shared byte address for all planes |
| mem_rd | output | 1 | Read request; data returns the next cycle |
| mem_we | output | 4 | Per-plane write strobe |
| mem_wdata | output | 32 | Write data, plane p in bits 8p+7..8p |
| mem_rdata | input | 32 | Read data, plane p in bits 8p+7..8p |

## Verification
A corrupted address walker shows up straight away at `mem_addr`, and after the first write it also shows as a destination byte outside the expected rectangle. A wrong count ends the run early or late, which changes the number of busy cycles. A wrong plane function, inversion or edge mask shows in the data of the first byte it reaches, one write cycle after the destination read. A rotate carry that is not cleared between lines spoils only the first byte of the next line, so the cases use several lines with a nonzero rotate and compare every byte of every plane against an independent model.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int NPLANES = 4;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 18;
    localparam int SPAN_W  = 16;
    localparam int LINES_W = 10;
    localparam int STEP_W  = 9;
    localparam int ROT_W   = 3;
    localparam int DATA_W  = NPLANES * BYTE_W;

    typedef enum logic [1:0] {
        ROP_COPY = 2'b00,
        ROP_AND  = 2'b01,
        ROP_OR   = 2'b10,
        ROP_XOR  = 2'b11
    } rop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WRITE,
        ST_FINISH
    } phase_e;

    typedef struct packed {
        logic [NPLANES-1:0] plane_mask;
        logic [NPLANES-1:0] lop0;
        logic [NPLANES-1:0] lop1;
        logic [NPLANES-1:0] src_inv;
        logic [NPLANES-1:0] dst_inv;
        logic [BYTE_W-1:0]  start_mask;
        logic [BYTE_W-1:0]  end_mask;
        logic [SPAN_W-1:0]  width;
        logic [LINES_W-1:0] height;
        logic [ADDR_W-1:0]  src_addr;
        logic [ADDR_W-1:0]  dst_addr;
        logic [STEP_W-1:0]  src_pitch;
        logic [STEP_W-1:0]  dst_pitch;
        logic [ROT_W-1:0]   rot;
        logic               dir;
    } cfg_t;

    // Right rotate across a byte boundary: the previous byte supplies the top bits.
    function automatic logic [BYTE_W-1:0] rot_join(input logic [BYTE_W-1:0] cur,
                                                   input logic [BYTE_W-1:0] prev,
                                                   input logic [ROT_W-1:0]  amt);
        logic [2*BYTE_W-1:0] pair;
        pair = {prev, cur} >> amt;
        return pair[BYTE_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] apply_rop(input rop_e op,
                                                    input logic [BYTE_W-1:0] s,
                                                    input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] r;
        unique case (op)
            ROP_COPY: r = s;
            ROP_AND:  r = s & d;
            ROP_OR:   r = s | d;
            default:  r = s ^ d;
        endcase
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] sext_step(input logic [STEP_W-1:0] p);
        return {{(ADDR_W-STEP_W){p[STEP_W-1]}}, p};
    endfunction

endpackage

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  logic   empty,
    input  logic   last_byte,
    output phase_e phase
);

    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            ST_IDLE:   if (go) phase_nx = empty ? ST_FINISH : ST_RD_SRC;
            ST_RD_SRC: phase_nx = ST_RD_DST;
            ST_RD_DST: phase_nx = ST_WRITE;
            ST_WRITE:  phase_nx = last_byte ? ST_FINISH : ST_RD_SRC;
            ST_FINISH: phase_nx = ST_IDLE;
            default:   phase_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= ST_IDLE;
        else     phase <= phase_nx;
    end

endmodule

// File: rtl/blit_walk.sv
module blit_walk
    import blit_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [ADDR_W-1:0]  src_start,
    input  logic [ADDR_W-1:0]  dst_start,
    input  logic [STEP_W-1:0]  src_pitch,
    input  logic [STEP_W-1:0]  dst_pitch,
    input  logic [SPAN_W-1:0]  width,
    input  logic [LINES_W-1:0] height,
    input  logic               dir,
    output logic [ADDR_W-1:0]  src_cur,
    output logic [ADDR_W-1:0]  dst_cur,
    output logic               first_x,
    output logic               last_x,
    output logic               last_y
);

    logic [ADDR_W-1:0]  src_line, dst_line;
    logic [ADDR_W-1:0]  src_inc, dst_inc;
    logic [SPAN_W-1:0]  x_left, width_q;
    logic [LINES_W-1:0] y_left;
    logic               dir_q;
    logic [ADDR_W-1:0]  src_line_nx, dst_line_nx;

    always_comb begin
        src_line_nx = src_line + src_inc;
        dst_line_nx = dst_line + dst_inc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_cur  <= '0;
            dst_cur  <= '0;
            src_line <= '0;
            dst_line <= '0;
            src_inc  <= '0;
            dst_inc  <= '0;
            x_left   <= '0;
            width_q  <= '0;
            y_left   <= '0;
            dir_q    <= 1'b0;
        end else if (load) begin
            src_cur  <= src_start;
            dst_cur  <= dst_start;
            src_line <= src_start;
            dst_line <= dst_start;
            src_inc  <= sext_step(src_pitch);
            dst_inc  <= sext_step(dst_pitch);
            x_left   <= width;
            width_q  <= width;
            y_left   <= height;
            dir_q    <= dir;
        end else if (step) begin
            if (x_left == '0) begin
                src_line <= src_line_nx;
                dst_line <= dst_line_nx;
                src_cur  <= src_line_nx;
                dst_cur  <= dst_line_nx;
                x_left   <= width_q;
                y_left   <= y_left - 1'b1;
            end else begin
                src_cur  <= dir_q ? src_cur - 1'b1 : src_cur + 1'b1;
                dst_cur  <= dir_q ? dst_cur - 1'b1 : dst_cur + 1'b1;
                x_left   <= x_left - 1'b1;
            end
        end
    end

    assign first_x = (x_left == width_q);
    assign last_x  = (x_left == '0);
    assign last_y  = (y_left == LINES_W'(1));

endmodule

// File: rtl/blit_plane_rop.sv
module blit_plane_rop
    import blit_pkg::*;
(
    input  logic [BYTE_W-1:0] src_byte,
    input  logic [BYTE_W-1:0] src_prev,
    input  logic [BYTE_W-1:0] dst_byte,
    input  logic [ROT_W-1:0]  rot,
    input  logic              op_lo,
    input  logic              op_hi,
    input  logic              sinv,
    input  logic              dinv,
    input  logic [BYTE_W-1:0] bit_mask,
    output logic [BYTE_W-1:0] wr_byte
);

    logic [BYTE_W-1:0] s_eff, d_eff, res;

    always_comb begin
        s_eff   = rot_join(src_byte, src_prev, rot) ^ {BYTE_W{sinv}};
        d_eff   = dst_byte ^ {BYTE_W{dinv}};
        res     = apply_rop(rop_e'({op_hi, op_lo}), s_eff, d_eff);
        wr_byte = (res & bit_mask) | (dst_byte & ~bit_mask);
    end

endmodule

// File: rtl/planar_blit.sv
module planar_blit
    import blit_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NPLANES-1:0] plane_en,
    input  logic [NPLANES-1:0] op_lo,
    input  logic [NPLANES-1:0] op_hi,
    input  logic [NPLANES-1:0] src_inv,
    input  logic [NPLANES-1:0] dst_inv,
    input  logic [BYTE_W-1:0]  head_mask,
    input  logic [BYTE_W-1:0]  tail_mask,
    input  logic [SPAN_W-1:0]  span,
    input  logic [LINES_W-1:0] lines,
    input  logic [ADDR_W-1:0]  src_base,
    input  logic [ADDR_W-1:0]  dst_base,
    input  logic [STEP_W-1:0]  src_step,
    input  logic [STEP_W-1:0]  dst_step,
    input  logic [ROT_W-1:0]   rot,
    input  logic               reverse,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic [NPLANES-1:0] mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);

    cfg_t              cfg_q;
    phase_e            phase;
    logic              load, step;
    logic [ADDR_W-1:0] src_cur, dst_cur;
    logic              first_x, last_x, last_y;
    logic [DATA_W-1:0] src_q, carry_q;
    logic [BYTE_W-1:0] edge_mask;

    assign load = start && (phase == ST_IDLE);
    assign step = (phase == ST_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= '{plane_mask: plane_en, lop0: op_lo, lop1: op_hi,
                       src_inv: src_inv, dst_inv: dst_inv,
                       start_mask: head_mask, end_mask: tail_mask,
                       width: span, height: lines,
                       src_addr: src_base, dst_addr: dst_base,
                       src_pitch: src_step, dst_pitch: dst_step,
                       rot: rot, dir: reverse};
        end
    end

    blit_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (load),
        .empty     (lines == '0),
        .last_byte (last_x && last_y),
        .phase     (phase)
    );

    blit_walk u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .src_start (src_base),
        .dst_start (dst_base),
        .src_pitch (src_step),
        .dst_pitch (dst_step),
        .width     (span),
        .height    (lines),
        .dir       (reverse),
        .src_cur   (src_cur),
        .dst_cur   (dst_cur),
        .first_x   (first_x),
        .last_x    (last_x),
        .last_y    (last_y)
    );

    // Source byte arrives during the destination read; carry follows each write.
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            carry_q <= '0;
        end else begin
            if (phase == ST_RD_DST) src_q <= mem_rdata;
            if (load)               carry_q <= '0;
            else if (step)          carry_q <= last_x ? '0 : src_q;
        end
    end

    always_comb begin
        unique case ({first_x, last_x})
            2'b11:   edge_mask = cfg_q.start_mask & cfg_q.end_mask;
            2'b10:   edge_mask = cfg_q.start_mask;
            2'b01:   edge_mask = cfg_q.end_mask;
            default: edge_mask = '1;
        endcase
    end

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        blit_plane_rop u_rop (
            .src_byte (src_q[p*BYTE_W +: BYTE_W]),
            .src_prev (carry_q[p*BYTE_W +: BYTE_W]),
            .dst_byte (mem_rdata[p*BYTE_W +: BYTE_W]),
            .rot      (cfg_q.rot),
            .op_lo    (cfg_q.lop0[p]),
            .op_hi    (cfg_q.lop1[p]),
            .sinv     (cfg_q.src_inv[p]),
            .dinv     (cfg_q.dst_inv[p]),
            .bit_mask (edge_mask),
            .wr_byte  (mem_wdata[p*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        busy     = (phase != ST_IDLE);
        done     = (phase == ST_FINISH);
        mem_rd   = (phase == ST_RD_SRC) || (phase == ST_RD_DST);
        mem_addr = (phase == ST_RD_SRC) ? src_cur : dst_cur;
        mem_we   = step ? cfg_q.plane_mask : '0;
    end

endmodule

// File: rtl/planar_blit_chk.sv
module planar_blit_chk
    import blit_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic               mem_rd,
    input logic [NPLANES-1:0] mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [NPLANES-1:0] pmask_q
);

    // R3: strobes stay inside the captured plane enable
    p_we_in_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we & ~pmask_q) == '0);

    // R8: a read and a write never share a cycle
    p_rd_we_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && (mem_we != '0)));

    // R8: a write always follows the destination read at the same address
    p_we_after_rd_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_we != '0) |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

    // R8: done is a single pulse that ends the operation
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R9: no memory traffic while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && mem_we == '0));

    // R10: the captured parameters cannot change during an operation
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pmask_q));

endmodule

bind planar_blit planar_blit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_rd   (mem_rd),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .pmask_q  (cfg_q.plane_mask)
);

// File: tb/planar_blit_test.sv
module planar_blit_test;
    import blit_pkg::*;

    localparam int MEMSZ = 1024;

    typedef struct packed {
        cfg_t        c;
        logic [31:0] cyc;
    } tv_t;

    // Fields: pmask lop0 lop1 sinv dinv head tail span lines src dst sstep dstep rot rev
    localparam tv_t TV [0:5] = '{
        '{'{4'hF, 4'b1010, 4'b1100, 4'h0, 4'h0, 8'hFF, 8'hFF, 16'd3, 10'd2,
            18'd16,  18'd200, 9'd32,  9'd32,  3'd0, 1'b0}, 32'd25},
        '{'{4'hF, 4'b1010, 4'b1100, 4'b0101, 4'b0011, 8'hF0, 8'h0F, 16'd5, 10'd3,
            18'd40,  18'd300, 9'd20,  9'd24,  3'd3, 1'b0}, 32'd55},
        '{'{4'b1010, 4'b0110, 4'b0011, 4'h0, 4'b1000, 8'h3C, 8'h66, 16'd0, 10'd4,
            18'd100, 18'd400, 9'd16,  9'd9,   3'd5, 1'b0}, 32'd13},
        '{'{4'hF, 4'b0011, 4'b0110, 4'b1001, 4'b0100, 8'hFE, 8'h7F, 16'd4, 10'd3,
            18'd500, 18'd800, 9'h1E0, 9'h1D8, 3'd2, 1'b1}, 32'd46},
        '{'{4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 8'hFF, 8'hFF, 16'd7, 10'd1,
            18'd600, 18'd602, 9'd0,   9'd0,   3'd1, 1'b0}, 32'd25},
        '{'{4'h0, 4'hF, 4'hF, 4'hF, 4'hF, 8'hFF, 8'hFF, 16'd2, 10'd2,
            18'd20,  18'd60,  9'd8,   9'd8,   3'd4, 1'b0}, 32'd19}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    cfg_t               drv = '0;
    logic               busy, done, mem_rd;
    logic [ADDR_W-1:0]  mem_addr;
    logic [NPLANES-1:0] mem_we;
    logic [DATA_W-1:0]  mem_wdata;
    logic [DATA_W-1:0]  mem_rdata = '0;
    logic               do_init = 1'b0;

    logic [7:0] mem  [NPLANES][MEMSZ];
    logic [7:0] refm [NPLANES][MEMSZ];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    planar_blit uut (
        .clk(clk), .rst(rst), .start(start),
        .plane_en(drv.plane_mask), .op_lo(drv.lop0), .op_hi(drv.lop1),
        .src_inv(drv.src_inv), .dst_inv(drv.dst_inv),
        .head_mask(drv.start_mask), .tail_mask(drv.end_mask),
        .span(drv.width), .lines(drv.height),
        .src_base(drv.src_addr), .dst_base(drv.dst_addr),
        .src_step(drv.src_pitch), .dst_step(drv.dst_pitch),
        .rot(drv.rot), .reverse(drv.dir),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] seed(int p, int a);
        return 8'((a * 37 + p * 91 + 13) ^ (a >> 3));
    endfunction

    always @(posedge clk) begin
        if (do_init) begin
            for (int p = 0; p < NPLANES; p++)
                for (int a = 0; a < MEMSZ; a++)
                    mem[p][a] <= seed(p, a);
        end else begin
            if (mem_rd)
                for (int p = 0; p < NPLANES; p++)
                    mem_rdata[p*8 +: 8] <= mem[p][mem_addr[9:0]];
            for (int p = 0; p < NPLANES; p++)
                if (mem_we[p]) mem[p][mem_addr[9:0]] <= mem_wdata[p*8 +: 8];
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Independent model of the operation on refm
    task automatic ref_blit(cfg_t c);
        int sp = int'($signed(c.src_pitch));
        int dp = int'($signed(c.dst_pitch));
        for (int p = 0; p < NPLANES; p++)
            for (int a = 0; a < MEMSZ; a++)
                refm[p][a] = mem[p][a];
        for (int y = 0; y < int'(c.height); y++) begin
            int prev [NPLANES];
            for (int p = 0; p < NPLANES; p++) prev[p] = 0;
            for (int x = 0; x <= int'(c.width); x++) begin
                int sl = int'(c.src_addr) + y * sp;
                int dl = int'(c.dst_addr) + y * dp;
                int sa = (c.dir ? sl - x : sl + x) & (MEMSZ - 1);
                int da = (c.dir ? dl - x : dl + x) & (MEMSZ - 1);
                int m  = 255;
                if (x == 0) m = m & int'(c.start_mask);
                if (x == int'(c.width)) m = m & int'(c.end_mask);
                for (int p = 0; p < NPLANES; p++) begin
                    int s = int'(refm[p][sa]);
                    int d = int'(refm[p][da]);
                    int r = (s >> c.rot) | ((prev[p] << (8 - int'(c.rot))) & 255);
                    int si, di, res;
                    prev[p] = s;
                    si = c.src_inv[p] ? r ^ 255 : r;
                    di = c.dst_inv[p] ? d ^ 255 : d;
                    case ({c.lop1[p], c.lop0[p]})
                        2'b00:   res = si;
                        2'b01:   res = si & di;
                        2'b10:   res = si | di;
                        default: res = si ^ di;
                    endcase
                    if (c.plane_mask[p])
                        refm[p][da] = 8'((res & m) | (d & ~m));
                end
            end
        end
    endtask

    task automatic run(cfg_t c, int exp_cyc, string req, bit inject);
        int cyc = 0, dones = 0, stray = 0, bad = 0, first_bad = -1;
        ref_blit(c);
        @(negedge clk);
        drv = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            cyc++;
            if (done) dones++;
            if ((mem_we & ~c.plane_mask) != '0) stray++;
            if (inject && cyc == 5) begin
                drv = TV[1].c;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        for (int p = 0; p < NPLANES; p++)
            for (int a = 0; a < MEMSZ; a++)
                if (mem[p][a] !== refm[p][a]) begin
                    bad++;
                    if (first_bad < 0) first_bad = p * MEMSZ + a;
                end
        if (bad != 0)
            $display("FAIL %s first wrong byte plane %0d addr %0d: actual %0d expected %0d",
                     req, first_bad / MEMSZ, first_bad % MEMSZ,
                     mem[first_bad / MEMSZ][first_bad % MEMSZ],
                     refm[first_bad / MEMSZ][first_bad % MEMSZ]);
        check(bad == 0, req, "mismatching bytes", bad, 0);
        check(cyc == exp_cyc, "R8", "busy cycles", cyc, exp_cyc);
        check(dones == 1, "R8", "done pulses", dones, 1);
        check(stray == 0, "R3", "strobes outside plane enable", stray, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_init = 1'b1;
        repeat (3) @(negedge clk);
        do_init = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
        check(done == 1'b0 && mem_rd == 1'b0 && mem_we == '0, "R9", "outputs in reset",
              int'({done, mem_rd, mem_we}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && mem_rd == 1'b0, "R9", "idle after reset", int'({busy, mem_rd}), 0);

        // Table: R1 functions, R2 inversion, R4 edges, R5 geometry, R6 reverse, R7 rotate
        for (int i = 0; i < 6; i++) begin
            string tag;
            case (i)
                0: tag = "R1/R5";
                1: tag = "R2/R4/R7";
                2: tag = "R4 one-byte line";
                3: tag = "R6 reverse";
                4: tag = "R7 overlap";
                default: tag = "R3 no planes";
            endcase
            run(TV[i].c, int'(TV[i].cyc), tag, 1'b0);
        end

        // R10: zero lines finishes in one cycle with no access
        begin
            cfg_t z = TV[0].c;
            z.height = '0;
            run(z, 1, "R10 zero lines", 1'b0);
        end

        // R10: start during an operation is ignored
        run(TV[3].c, int'(TV[3].cyc), "R10 start while busy", 1'b1);

        // R9: synchronous reset mid-operation returns to idle
        @(negedge clk);
        drv = TV[1].c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && mem_we == '0, "R9", "busy after mid-run reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule